// File: doc/BRIEF.md
# Asynchronous Schedule Traversal Controller

This block walks a circular chain of queue-head descriptors that carry control and bulk transfers. Software loads a list pointer register and sets an enable bit. A status bit reports whether the schedule is really running. The status bit follows the enable bit only when a micro-frame tick is handled while the walker is idle. Each time a service pass starts, the walker takes the queue head named by the list pointer and hands its address to an external transaction engine. It waits for the engine to finish, then reads that queue head's horizontal link word over a valid/ready memory port and moves on to the next entry.

A pass ends at the end of a micro-frame, when software clears the enable bit, or when a whole lap completes with no executed transaction (an empty list). At each of these endings the walker writes the link pointer it fetched last back into the list pointer register. The next pass therefore resumes at the entry after the last one served, which gives round-robin service. A malformed link word raises an error flag and stops the pass at once.

Top module: `async_sched_walker`

## Requirements
- R1: A write with `en_we` high loads `en_wdata` into the enable bit, and the new value is visible on `sched_en` from the next cycle. After reset both `sched_en` and `sched_sts` read 0.
- R2: The status bit `sched_sts` changes only when a pending micro-frame tick is handled while the walker is idle, and it then takes the enable bit's value. A pass starts in that same cycle when the enable bit is 1, and no queue head is presented or fetched while `sched_sts` is 0.
- R3: A write with `base_we` high updates the list pointer only while `sched_en` and `sched_sts` are both 0. Address bits [4:0] are stored as zero, and at any other time the write is ignored.
- R4: Each pass first presents the queue head held in the list pointer on `xfer_addr`. After `xfer_done`, the walker reads the link word at that same address, and only after that does it present the next entry.
- R5: The link word is decoded as follows: bits [31:5] give the next queue-head address, bits [2:1] give the type (01 marks a queue head), and bit 0 is the terminate flag. Valid links are followed in circular order.
- R6: A micro-frame tick that arrives during a pass ends the pass after the next link word returns. The pointer from that link is written into the list pointer.
- R7: Clearing the enable bit during a pass ends it in the same way as R6. `sched_sts` stays 1 until the next tick is handled while the walker is idle.
- R8: When the traversal comes back to the pass's first queue head and no `xfer_done` with `xfer_exec` high was seen in that lap, the pass ends with the list pointer equal to that first queue head. If a transaction did execute, the walker starts a new lap.
- R9: A link word whose type is not 01, or whose terminate bit is 1, sets `link_err` and ends the pass with no write-back. `link_err` clears when the next pass starts.
- R10: `xfer_valid` and `xfer_addr` hold until `xfer_done`. `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`.
- R11: The pass after a write-back starts at the written-back queue head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_we | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | New enable value |
| base_we | input | 1 | Write strobe for the list pointer |
| base_wdata | input | 32 | New list pointer |
| uframe_tick | input | 1 | End-of-micro-frame pulse |
| sched_en | output | 1 | Enable bit |
| sched_sts | output | 1 | Status bit |
| base_addr | output | 32 | List pointer readback |
| busy | output | 1 | A pass is in progress |
| link_err | output | 1 | Malformed link seen in the last pass |
| xfer_valid | output | 1 | Queue head presented to the engine |
| xfer_addr | output | 32 | Presented queue-head address |
| xfer_done | input | 1 | Engine finished with the presented queue head |
| xfer_exec | input | 1 | Engine executed a transaction (with done) |
| mem_req_valid | output | 1 | Link read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Link read address |
| mem_rsp_valid | input | 1 | Link word returned |
| mem_rsp_data | input | 32 | Link word |

## Verification
Two endings of a pass can land in the same cycle: a micro-frame tick can arrive together with the link response that closes an empty lap. The bench provokes this from its memory model, which pulses the tick in the same cycle that it returns the link pointing back to the lap's first entry. The expected result is a single write-back of that first entry. The tick stays pending, so a fresh pass has to start from that same entry with no further tick. This is judged by the count and order of the presented addresses.

// File: rtl/asw_pkg.sv
package asw_pkg;
    localparam int ADDR_W  = 32;
    localparam int PTR_LSB = 5;
    localparam logic [1:0] LINK_QH = 2'b01;

    typedef enum logic [1:0] {
        W_IDLE,
        W_XFER,
        W_FETCH,
        W_RESP
    } walk_st_e;
endpackage

// File: rtl/asw_gate.sv
module asw_gate
    import asw_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int LSB = PTR_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_we,
    input  logic          en_wdata,
    input  logic          base_we,
    input  logic [AW-1:0] base_wdata,
    input  logic          uframe_tick,
    input  logic          walk_busy,
    input  logic          wb_valid,
    input  logic [AW-LSB-1:0] wb_ptr,
    output logic          en_o,
    output logic          sts_o,
    output logic [AW-1:0] base_o,
    output logic [AW-LSB-1:0] base_ptr_o,
    output logic          stop_o,
    output logic          start_o
);
    localparam int PW = AW - LSB;

    typedef struct packed {
        logic          en;
        logic          sts;
        logic          pend;
        logic [PW-1:0] ptr;
    } gate_t;

    gate_t r_q, r_d;
    logic  consume;
    logic  unused_low;

    assign unused_low = ^base_wdata[LSB-1:0];

    always_comb begin
        r_d     = r_q;
        consume = r_q.pend && !walk_busy;
        start_o = consume && r_q.en;
        if (en_we) r_d.en = en_wdata;
        if (consume) begin
            r_d.sts  = r_q.en;
            r_d.pend = 1'b0;
        end
        if (uframe_tick) r_d.pend = 1'b1;
        if (wb_valid) begin
            r_d.ptr = wb_ptr;
        end else if (base_we && !r_q.en && !r_q.sts) begin
            r_d.ptr = base_wdata[AW-1:LSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en_o       = r_q.en;
    assign sts_o      = r_q.sts;
    assign base_ptr_o = r_q.ptr;
    assign base_o     = {r_q.ptr, {LSB{1'b0}}};
    assign stop_o     = r_q.pend || !r_q.en;

    a_r3_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.en || r_q.sts) && !wb_valid) |=> $stable(base_o));

    a_r2_sts_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.pend && !walk_busy) |=> $stable(r_q.sts));

    a_r2_sts_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pend && !walk_busy) |=> (r_q.sts == $past(r_q.en)));
endmodule

// File: rtl/asw_walk.sv
module asw_walk
    import asw_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int LSB = PTR_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-LSB-1:0] base_ptr,
    input  logic          stop_req,
    output logic          xfer_valid,
    output logic [AW-1:0] xfer_addr,
    input  logic          xfer_done,
    input  logic          xfer_exec,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data,
    output logic          wb_valid,
    output logic [AW-LSB-1:0] wb_ptr,
    output logic          busy,
    output logic          err_o
);
    localparam int PW = AW - LSB;

    typedef struct packed {
        walk_st_e      st;
        logic [PW-1:0] cur;
        logic [PW-1:0] lap;
        logic          work;
        logic          err;
    } walk_t;

    walk_t r_q, r_d;
    logic [PW-1:0] link_nxt;
    logic          link_ok;
    logic          lap_end;
    logic          unused_rsv;

    assign link_nxt   = mem_rsp_data[AW-1:LSB];
    assign link_ok    = (mem_rsp_data[2:1] == LINK_QH) && !mem_rsp_data[0];
    assign lap_end    = (link_nxt == r_q.lap);
    assign unused_rsv = ^mem_rsp_data[LSB-1:3];

    always_comb begin
        r_d      = r_q;
        wb_valid = 1'b0;
        wb_ptr   = r_q.cur;
        case (r_q.st)
            W_IDLE: begin
                if (start) begin
                    r_d.st   = W_XFER;
                    r_d.cur  = base_ptr;
                    r_d.lap  = base_ptr;
                    r_d.work = 1'b0;
                    r_d.err  = 1'b0;
                end
            end
            W_XFER: begin
                if (xfer_done) begin
                    r_d.work = r_q.work || xfer_exec;
                    r_d.st   = W_FETCH;
                end
            end
            W_FETCH: begin
                if (mem_req_ready) r_d.st = W_RESP;
            end
            W_RESP: begin
                if (mem_rsp_valid) begin
                    if (!link_ok) begin
                        r_d.err = 1'b1;
                        r_d.st  = W_IDLE;
                    end else begin
                        r_d.cur = link_nxt;
                        if (stop_req || (lap_end && !r_q.work)) begin
                            wb_valid = 1'b1;
                            wb_ptr   = link_nxt;
                            r_d.st   = W_IDLE;
                        end else begin
                            r_d.st = W_XFER;
                            if (lap_end) r_d.work = 1'b0;
                        end
                    end
                end
            end
            default: r_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: W_IDLE, cur: '0, lap: '0, work: 1'b0, err: 1'b0};
        else        r_q <= r_d;
    end

    assign xfer_valid    = (r_q.st == W_XFER);
    assign mem_req_valid = (r_q.st == W_FETCH);
    assign xfer_addr     = {r_q.cur, {LSB{1'b0}}};
    assign mem_req_addr  = {r_q.cur, {LSB{1'b0}}};
    assign busy          = (r_q.st != W_IDLE);
    assign err_o         = r_q.err;

    a_r10_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_done) |=> (xfer_valid && $stable(xfer_addr)));

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r4_fetch_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> ($past(xfer_valid && xfer_done) && mem_req_addr == $past(xfer_addr)));

    a_r9_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy);

    a_r6_wb_ends_pass: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !busy);
endmodule

// File: rtl/async_sched_walker.sv
module async_sched_walker
    import asw_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int LSB = PTR_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_we,
    input  logic          en_wdata,
    input  logic          base_we,
    input  logic [AW-1:0] base_wdata,
    input  logic          uframe_tick,
    output logic          sched_en,
    output logic          sched_sts,
    output logic [AW-1:0] base_addr,
    output logic          busy,
    output logic          link_err,
    output logic          xfer_valid,
    output logic [AW-1:0] xfer_addr,
    input  logic          xfer_done,
    input  logic          xfer_exec,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [AW-1:0] mem_rsp_data
);
    localparam int PW = AW - LSB;

    logic          wb_valid;
    logic [PW-1:0] wb_ptr;
    logic [PW-1:0] base_ptr;
    logic          stop_req;
    logic          start;

    asw_gate #(.AW(AW), .LSB(LSB)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we      (en_we),
        .en_wdata   (en_wdata),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .uframe_tick(uframe_tick),
        .walk_busy  (busy),
        .wb_valid   (wb_valid),
        .wb_ptr     (wb_ptr),
        .en_o       (sched_en),
        .sts_o      (sched_sts),
        .base_o     (base_addr),
        .base_ptr_o (base_ptr),
        .stop_o     (stop_req),
        .start_o    (start)
    );

    asw_walk #(.AW(AW), .LSB(LSB)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .base_ptr     (base_ptr),
        .stop_req     (stop_req),
        .xfer_valid   (xfer_valid),
        .xfer_addr    (xfer_addr),
        .xfer_done    (xfer_done),
        .xfer_exec    (xfer_exec),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .wb_valid     (wb_valid),
        .wb_ptr       (wb_ptr),
        .busy         (busy),
        .err_o        (link_err)
    );

    a_r2_service_needs_sts: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid || mem_req_valid) |-> sched_sts);

    a_r4_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_valid, mem_req_valid}));
endmodule

// File: tb/async_sched_walker_test.sv
`timescale 1ns/1ps
module async_sched_walker_test;
    localparam logic [31:0] ABASE = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_we = 1'b0, en_wdata = 1'b0, base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        tick_drv = 1'b0, tick_mdl = 1'b0;
    logic        uframe_tick;
    logic        sched_en, sched_sts, busy, link_err;
    logic [31:0] base_addr, xfer_addr, mem_req_addr;
    logic        xfer_valid, mem_req_valid;
    logic        xfer_done = 1'b0, xfer_exec = 1'b0;
    logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    assign uframe_tick = tick_drv | tick_mdl;

    always #2.5 clk = ~clk;

    async_sched_walker uut (
        .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
        .base_we(base_we), .base_wdata(base_wdata), .uframe_tick(uframe_tick),
        .sched_en(sched_en), .sched_sts(sched_sts), .base_addr(base_addr),
        .busy(busy), .link_err(link_err), .xfer_valid(xfer_valid),
        .xfer_addr(xfer_addr), .xfer_done(xfer_done), .xfer_exec(xfer_exec),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    logic [31:0] mem [0:7];
    logic [31:0] log_addr [0:63];
    int          log_cnt = 0;
    int          nchk = 0, nfail = 0, cyc = 0;
    bit          exec_mode = 1'b1;
    bit          close_arm = 1'b0;
    logic [31:0] close_lap = '0;
    bit          hs_pend = 1'b0;
    logic [31:0] hs_addr = '0;
    int          eng_wait = 0;

    function automatic logic [31:0] qa(input int i);
        return ABASE + 32'(i) * 32;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                nchk++;
                nfail++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                finish_run();
            end
        end
    end

    // memory model for link reads
    initial begin
        forever begin
            @(negedge clk);
            tick_mdl      = 1'b0;
            mem_rsp_valid = 1'b0;
            if (hs_pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[3'((hs_addr - ABASE) >> 5)];
                if (close_arm && ((mem_rsp_data & 32'hFFFF_FFE0) == close_lap)) begin
                    tick_mdl  = 1'b1;
                    close_arm = 1'b0;
                end
                hs_pend = 1'b0;
            end
            mem_req_ready = (cyc % 3) != 1;
            if (mem_req_valid && mem_req_ready) begin
                hs_pend = 1'b1;
                hs_addr = mem_req_addr;
                chk("R4 link read address", mem_req_addr, log_addr[log_cnt-1]);
            end
        end
    end

    // transaction engine model
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_done) begin
                xfer_done = 1'b0;
            end else if (xfer_valid) begin
                if (eng_wait > 0) begin
                    eng_wait--;
                end else begin
                    xfer_done = 1'b1;
                    xfer_exec = exec_mode;
                    if (log_cnt < 64) log_addr[log_cnt] = xfer_addr;
                    log_cnt++;
                    eng_wait = log_cnt % 2;
                end
            end
        end
    end

    task automatic tick();
        tick_drv = 1'b1;
        @(negedge clk);
        tick_drv = 1'b0;
    endtask

    task automatic write_base(input logic [31:0] a);
        base_we = 1'b1;
        base_wdata = a;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic set_en(input logic v);
        en_we = 1'b1;
        en_wdata = v;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic wait_log(input int k);
        while (log_cnt < k) @(negedge clk);
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic build(input int n);
        for (int i = 0; i < 8; i++) mem[i] = qa((i + 1) % n) | 32'h2;
    endtask

    task automatic shut_down();
        set_en(1'b0);
        wait_idle();
        tick();
        @(negedge clk);
        chk("R2 status drops on tick", {31'b0, sched_sts}, 32'd0);
    endtask

    // round-robin pass stopped by a tick, then a pass stopped by disable
    task automatic run_rr(input int n, input int s, input int k);
        build(n);
        exec_mode = 1'b1;
        log_cnt = 0;
        write_base(qa(s) | 32'h1F);
        chk("R3 write accepted and aligned", base_addr, qa(s));
        set_en(1'b1);
        chk("R1 enable bit set", {31'b0, sched_en}, 32'd1);
        chk("R2 status lags enable", {31'b0, sched_sts}, 32'd0);
        write_base(qa((s + 1) % n));
        chk("R3 write ignored with enable set", base_addr, qa(s));
        tick();
        wait_log(k);
        tick();
        wait_log(k + 1);
        set_en(1'b0);
        for (int j = 0; j < k; j++)
            chk("R5 traversal order", log_addr[j], qa((s + j) % n));
        chk("R11 resume after micro-frame end", log_addr[k], qa((s + k) % n));
        wait_idle();
        chk("R7 disable writes back next pointer", base_addr, qa((s + k + 1) % n));
        chk("R7 status held after disable", {31'b0, sched_sts}, 32'd1);
        chk("R6 served count", 32'(log_cnt), 32'(k + 1));
        tick();
        @(negedge clk);
        chk("R2 status follows cleared enable", {31'b0, sched_sts}, 32'd0);
    endtask

    // empty list: one lap with no executed transaction
    task automatic run_empty(input int n, input int s);
        build(n);
        exec_mode = 1'b0;
        log_cnt = 0;
        write_base(qa(s));
        set_en(1'b1);
        tick();
        wait_idle();
        chk("R8 empty lap length", 32'(log_cnt), 32'(n));
        for (int j = 0; j < n; j++)
            chk("R8 empty lap order", log_addr[j], qa((s + j) % n));
        chk("R8 pointer back at lap start", base_addr, qa(s));
        write_base(qa((s + 1) % n));
        chk("R3 write ignored while running", base_addr, qa(s));
        set_en(1'b0);
        write_base(qa((s + 1) % n));
        chk("R3 write ignored while status set", base_addr, qa(s));
        tick();
        @(negedge clk);
        chk("R2 status cleared", {31'b0, sched_sts}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 enable after reset", {31'b0, sched_en}, 32'd0);
        chk("R2 status after reset", {31'b0, sched_sts}, 32'd0);
        chk("R4 no request after reset", {30'b0, xfer_valid, mem_req_valid}, 32'd0);
        chk("R9 error after reset", {31'b0, link_err}, 32'd0);

        for (int n = 3; n <= 5; n++) begin
            for (int s = 0; s < n; s++) begin
                run_rr(n, s, 1);
                run_rr(n, s, n + 1);
                run_empty(n, s);
            end
        end

        // collision: tick together with the lap-closing link response
        build(4);
        exec_mode = 1'b0;
        log_cnt = 0;
        write_base(qa(1));
        set_en(1'b1);
        close_lap = qa(1);
        close_arm = 1'b1;
        tick();
        wait_log(8);
        wait_idle();
        chk("R6 collision second pass ran", 32'(log_cnt), 32'd8);
        chk("R11 collision resume entry", log_addr[4], qa(1));
        chk("R8 collision pointer", base_addr, qa(1));
        shut_down();

        // malformed links
        build(3);
        exec_mode = 1'b1;
        log_cnt = 0;
        mem[1] = qa(2);
        write_base(qa(0));
        set_en(1'b1);
        tick();
        wait_log(2);
        wait_idle();
        chk("R9 bad type flagged", {31'b0, link_err}, 32'd1);
        chk("R9 pass halted", 32'(log_cnt), 32'd2);
        chk("R9 pointer unchanged", base_addr, qa(0));
        mem[1] = qa(2) | 32'h3;
        tick();
        @(negedge clk);
        chk("R9 error cleared at pass start", {31'b0, link_err}, 32'd0);
        wait_log(4);
        wait_idle();
        chk("R9 terminate flagged", {31'b0, link_err}, 32'd1);
        chk("R9 halted again", 32'(log_cnt), 32'd4);
        chk("R11 restart from held pointer", log_addr[2], qa(0));
        mem[1] = qa(2) | 32'h2;
        shut_down();

        finish_run();
    end
endmodule